// File: doc/BRIEF.md
# Nibble-Serial Firmware Bus Target

This block is the target side of a 4-bit multiplexed firmware bus. A host frames each access by raising `frame_start` for one clock while it puts a start code on the nibble bus. Every later field is one nibble wide and lasts one clock. The block decodes the fields in a fixed order: an ID-select nibble, then seven address nibbles, then, for a write only, two data nibbles. It next turns the bus around, takes it over, reports a sync code and, for a read only, returns two data nibbles. At the end it hands the bus back.

The block compares the ID-select nibble with four strap pins. The boot device is strapped 0000 and further devices count upward from there. Accesses meant for another device leave this target silent. Each accepted access becomes exactly one single-byte request on a plain synchronous memory port. That port returns read data one clock after the request.

Top module: `fwh_target`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block returns to idle: from the next clock `bus_oe` and `mem_req` are low. A reset in the middle of an access abandons that access.
- R2: With `frame_start` high, nibble 4'hD starts a read and 4'hE starts a write. Any other nibble starts nothing, so no drive and no request follow.
- R3: The nibble after the start is the ID select. If it differs from `id_strap`, the target neither drives the bus nor issues a request for the rest of that access.
- R4: The seven nibbles after the ID select form a 28-bit address, most significant nibble first. Only the low 20 bits reach `mem_addr`, so the upper bits have no effect on which byte is accessed.
- R5: A write carries two data nibbles after the address, low nibble first. It makes exactly one `mem_req` pulse with `mem_we` high in the clock after the high data nibble, which is field 11 when the start field is field 0.
- R6: A read makes one `mem_req` pulse with `mem_we` low in field 9. The target does not drive the bus during that request clock.
- R7: One clock after its request, the target takes the bus and drives 4'hF. In the next clock it drives the ready sync code 4'h0.
- R8: On a read, the two clocks after the sync carry the byte that was read: the low nibble in field 12 and the high nibble in field 13.
- R9: After its last field (the sync on a write, the high data nibble on a read), the target drives 4'hF for one clock and then floats the bus.
- R10: A `frame_start` pulse in any state aborts the access in progress, even one in which the target is driving. The target releases the bus in the next clock and decodes the pulse's nibble as a new start code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | High for the start field of an access |
| bus_in | input | 4 | Nibble sampled from the shared bus |
| bus_out | output | 4 | Nibble driven onto the shared bus when enabled |
| bus_oe | output | 1 | Drive enable for `bus_out` |
| id_strap | input | 4 | Device ID straps |
| mem_req | output | 1 | One-clock memory request |
| mem_we | output | 1 | Request is a write when high |
| mem_addr | output | MEM_AW | Byte address of the request |
| mem_wdata | output | DATA_W | Byte to write |
| mem_rdata | input | DATA_W | Byte read, valid one clock after a read request |

## Verification
Number the fields from 0 at the start nibble. For a read, the request is due in field 9, the takeover ones in field 10, the sync in 11, the data in 12 and 13, the closing ones in 14 and the float in 15. A write shifts the request to field 11 and the takeover, sync and closing ones to fields 12, 13 and 14, with the float in 15. The bench builds the whole expected per-field trace of each access before it starts. In every clock it checks the outputs at the falling edge and only then applies that field's nibble, so each comparison sees the state left by the previous rising edge. Aborted and reset accesses are played up to a chosen field, and the next access states what it expects to see in its own first clock.

// File: rtl/fwh_tgt_pkg.sv
package fwh_tgt_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_IDSEL,
      ST_ADDR,
      ST_WDATA,
      ST_TAR_IN,
      ST_TAR_OWN,
      ST_SYNC,
      ST_RDATA,
      ST_TAR_OUT
   } fwh_state_e;

   localparam logic [3:0] NIB_START_RD   = 4'hD;
   localparam logic [3:0] NIB_START_WR   = 4'hE;
   localparam logic [3:0] NIB_ONES       = 4'hF;
   localparam logic [3:0] NIB_SYNC_READY = 4'h0;

endpackage

// File: rtl/fwh_tgt_seq.sv
module fwh_tgt_seq
   import fwh_tgt_pkg::*;
#(
   parameter int ADDR_NIBS = 7,
   parameter int DATA_NIBS = 2,
   parameter int CNT_W     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic [3:0]       nib_in,
   input  logic [3:0]       id_strap,
   output fwh_state_e       state,
   output logic [CNT_W-1:0] field_cnt,
   output logic             is_write
);

   localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIBS - 1);
   localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_NIBS - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         field_cnt <= '0;
         is_write  <= 1'b0;
      end else if (frame_start) begin
         field_cnt <= '0;
         if (nib_in == NIB_START_RD) begin
            state    <= ST_IDSEL;
            is_write <= 1'b0;
         end else if (nib_in == NIB_START_WR) begin
            state    <= ST_IDSEL;
            is_write <= 1'b1;
         end else begin
            state <= ST_IDLE;
         end
      end else begin
         case (state)
            ST_IDSEL: begin
               field_cnt <= '0;
               state     <= (nib_in == id_strap) ? ST_ADDR : ST_IDLE;
            end
            ST_ADDR: begin
               if (field_cnt == ADDR_LAST) begin
                  field_cnt <= '0;
                  state     <= is_write ? ST_WDATA : ST_TAR_IN;
               end else begin
                  field_cnt <= field_cnt + 1'b1;
               end
            end
            ST_WDATA: begin
               if (field_cnt == DATA_LAST) begin
                  field_cnt <= '0;
                  state     <= ST_TAR_IN;
               end else begin
                  field_cnt <= field_cnt + 1'b1;
               end
            end
            ST_TAR_IN:  state <= ST_TAR_OWN;
            ST_TAR_OWN: state <= ST_SYNC;
            ST_SYNC: begin
               field_cnt <= '0;
               state     <= is_write ? ST_TAR_OUT : ST_RDATA;
            end
            ST_RDATA: begin
               if (field_cnt == DATA_LAST) begin
                  field_cnt <= '0;
                  state     <= ST_TAR_OUT;
               end else begin
                  field_cnt <= field_cnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/fwh_tgt_capture.sv
module fwh_tgt_capture
   import fwh_tgt_pkg::*;
#(
   parameter int MEM_AW    = 20,
   parameter int DATA_W    = 8,
   parameter int DATA_NIBS = 2,
   parameter int CNT_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  fwh_state_e        state,
   input  logic [CNT_W-1:0]  field_cnt,
   input  logic [3:0]        nib_in,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [MEM_AW-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rdata_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         rdata_q <= '0;
      end else begin
         if (state == ST_ADDR)
            addr_q <= MEM_AW'({addr_q, nib_in});
         if (state == ST_TAR_OWN)
            rdata_q <= mem_rdata;
      end
   end

   for (genvar g = 0; g < DATA_NIBS; g++) begin : g_wnib
      logic [3:0] nib_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            nib_q <= '0;
         else if (state == ST_WDATA && field_cnt == CNT_W'(g))
            nib_q <= nib_in;
      end
      assign wdata_q[g*4 +: 4] = nib_q;
   end

endmodule

// File: rtl/fwh_tgt_drive.sv
module fwh_tgt_drive
   import fwh_tgt_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int DATA_NIBS = 2,
   parameter int CNT_W     = 3
) (
   input  fwh_state_e        state,
   input  logic [CNT_W-1:0]  field_cnt,
   input  logic [DATA_W-1:0] rdata_q,
   output logic [3:0]        bus_out,
   output logic              bus_oe
);

   logic [3:0] rd_nib;

   always_comb begin
      rd_nib = '0;
      for (int i = 0; i < DATA_NIBS; i++)
         if (field_cnt == CNT_W'(i))
            rd_nib = rdata_q[i*4 +: 4];
   end

   always_comb begin
      bus_oe  = 1'b0;
      bus_out = NIB_ONES;
      case (state)
         ST_TAR_OWN: begin bus_oe = 1'b1; bus_out = NIB_ONES;       end
         ST_SYNC:    begin bus_oe = 1'b1; bus_out = NIB_SYNC_READY; end
         ST_RDATA:   begin bus_oe = 1'b1; bus_out = rd_nib;         end
         ST_TAR_OUT: begin bus_oe = 1'b1; bus_out = NIB_ONES;       end
         default:    begin bus_oe = 1'b0; bus_out = NIB_ONES;       end
      endcase
   end

endmodule

// File: rtl/fwh_target.sv
module fwh_target
   import fwh_tgt_pkg::*;
#(
   parameter int ADDR_NIBS = 7,
   parameter int MEM_AW    = 20,
   parameter int DATA_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic [3:0]        bus_in,
   output logic [3:0]        bus_out,
   output logic              bus_oe,
   input  logic [3:0]        id_strap,
   output logic              mem_req,
   output logic              mem_we,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);

   localparam int ADDR_W    = ADDR_NIBS * 4;
   localparam int DATA_NIBS = DATA_W / 4;
   localparam int MAX_NIBS  = (ADDR_NIBS > DATA_NIBS) ? ADDR_NIBS : DATA_NIBS;
   localparam int CNT_W     = (MAX_NIBS > 1) ? $clog2(MAX_NIBS) : 1;

   if (MEM_AW > ADDR_W || MEM_AW < 4) begin : g_bad_aw
      $error("MEM_AW must lie between 4 and the address field width");
   end
   if (DATA_W % 4 != 0 || DATA_W < 4) begin : g_bad_dw
      $error("DATA_W must be a positive multiple of 4");
   end

   fwh_state_e       state;
   logic [CNT_W-1:0] field_cnt;
   logic             is_write;
   logic [DATA_W-1:0] rdata_q;

   fwh_tgt_seq #(
      .ADDR_NIBS (ADDR_NIBS),
      .DATA_NIBS (DATA_NIBS),
      .CNT_W     (CNT_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .nib_in      (bus_in),
      .id_strap    (id_strap),
      .state       (state),
      .field_cnt   (field_cnt),
      .is_write    (is_write)
   );

   fwh_tgt_capture #(
      .MEM_AW    (MEM_AW),
      .DATA_W    (DATA_W),
      .DATA_NIBS (DATA_NIBS),
      .CNT_W     (CNT_W)
   ) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .state     (state),
      .field_cnt (field_cnt),
      .nib_in    (bus_in),
      .mem_rdata (mem_rdata),
      .addr_q    (mem_addr),
      .wdata_q   (mem_wdata),
      .rdata_q   (rdata_q)
   );

   fwh_tgt_drive #(
      .DATA_W    (DATA_W),
      .DATA_NIBS (DATA_NIBS),
      .CNT_W     (CNT_W)
   ) u_drv (
      .state     (state),
      .field_cnt (field_cnt),
      .rdata_q   (rdata_q),
      .bus_out   (bus_out),
      .bus_oe    (bus_oe)
   );

   assign mem_req = (state == ST_TAR_IN);
   assign mem_we  = is_write;

endmodule

// File: rtl/fwh_target_chk.sv
module fwh_target_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       frame_start,
   input logic [3:0] bus_out,
   input logic       bus_oe,
   input logic       mem_req
);

   // R1: a reset edge leaves the bus released and no request pending
   p_reset_idle_r1: assert property (@(posedge clk)
      !rst_n |=> (!bus_oe && !mem_req));

   // R5: every request is a single-clock pulse
   p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   // R6: the request clock is still a turnaround clock with the bus free
   p_req_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !bus_oe);

   // R7: taking the bus starts with all ones
   p_take_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_oe) |-> (bus_out == 4'hF));

   // R9: a normal release is preceded by an all-ones clock
   p_release_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bus_oe) && $past(rst_n) && !$past(frame_start))
         |-> ($past(bus_out) == 4'hF));

endmodule

bind fwh_target fwh_target_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_start (frame_start),
   .bus_out     (bus_out),
   .bus_oe      (bus_oe),
   .mem_req     (mem_req)
);

// File: tb/fwh_target_test.sv
`timescale 1ns/1ps
module fwh_target_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        frame_start;
   logic [3:0]  bus_in;
   logic [3:0]  bus_out;
   logic        bus_oe;
   logic [3:0]  id_strap;
   logic        mem_req;
   logic        mem_we;
   logic [19:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata;

   int n_tests = 0;
   int n_fail  = 0;

   logic [7:0] mem     [int];
   logic [7:0] ref_mem [int];

   always #2.5 clk = ~clk;

   fwh_target uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .bus_in      (bus_in),
      .bus_out     (bus_out),
      .bus_oe      (bus_oe),
      .id_strap    (id_strap),
      .mem_req     (mem_req),
      .mem_we      (mem_we),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .mem_rdata   (mem_rdata)
   );

   // memory behind the port: one clock read latency
   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we)
            mem[int'(mem_addr)] = mem_wdata;
         else
            mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // one bus clock: check the outputs of this field, then apply its inputs
   task automatic cyc(input bit fr, input logic [3:0] nib, input bit eoe,
                      input logic [3:0] eout, input bit ereq, input bit ewe,
                      input logic [19:0] eaddr, input logic [7:0] ewd,
                      input string tag);
      @(negedge clk);
      chk({tag, " oe"}, 32'(bus_oe), 32'(eoe));
      if (eoe) chk({tag, " out"}, 32'(bus_out), 32'(eout));
      chk({tag, " req"}, 32'(mem_req), 32'(ereq));
      if (ereq) begin
         chk({tag, " we"}, 32'(mem_we), 32'(ewe));
         chk({tag, " addr"}, 32'(mem_addr), 32'(eaddr));
         if (ewe) chk({tag, " wdata"}, 32'(mem_wdata), 32'(ewd));
      end
      frame_start = fr;
      bus_in      = nib;
   endtask

   function automatic logic [7:0] ref_rd(input logic [19:0] a);
      return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
   endfunction

   // builds the expected per-field trace of one access, then plays it
   task automatic xfer(input bit wr, input logic [3:0] code, input logic [3:0] idn,
                       input logic [27:0] a, input logic [7:0] d, input int stop,
                       input bit f_oe, input logic [3:0] f_out);
      logic [3:0] q_nib[$];
      bit         q_oe[$];
      logic [3:0] q_out[$];
      bit         q_req[$];
      string      q_tag[$];
      bit         m;
      logic [7:0] rd;
      m  = (idn == id_strap) && (code == 4'hD || code == 4'hE);
      rd = ref_rd(a[19:0]);
      q_nib.push_back(code); q_oe.push_back(f_oe); q_out.push_back(f_out);
      q_req.push_back(1'b0); q_tag.push_back("R2 R10 start");
      q_nib.push_back(idn); q_oe.push_back(1'b0); q_out.push_back(4'hF);
      q_req.push_back(1'b0); q_tag.push_back("R3 R10 idsel");
      for (int i = 0; i < 7; i++) begin
         q_nib.push_back(a[27-4*i -: 4]); q_oe.push_back(1'b0); q_out.push_back(4'hF);
         q_req.push_back(1'b0); q_tag.push_back("R3 R4 addr");
      end
      if (wr) begin
         q_nib.push_back(d[3:0]); q_oe.push_back(1'b0); q_out.push_back(4'hF);
         q_req.push_back(1'b0); q_tag.push_back("R5 wdata lo");
         q_nib.push_back(d[7:4]); q_oe.push_back(1'b0); q_out.push_back(4'hF);
         q_req.push_back(1'b0); q_tag.push_back("R5 wdata hi");
         q_nib.push_back(4'hF); q_oe.push_back(1'b0); q_out.push_back(4'hF);
         q_req.push_back(m); q_tag.push_back("R5 write request");
      end else begin
         q_nib.push_back(4'hF); q_oe.push_back(1'b0); q_out.push_back(4'hF);
         q_req.push_back(m); q_tag.push_back("R6 read request");
      end
      q_nib.push_back(4'hF); q_oe.push_back(m); q_out.push_back(4'hF);
      q_req.push_back(1'b0); q_tag.push_back("R7 take ones");
      q_nib.push_back(4'hF); q_oe.push_back(m); q_out.push_back(4'h0);
      q_req.push_back(1'b0); q_tag.push_back("R7 sync");
      if (!wr) begin
         q_nib.push_back(4'hF); q_oe.push_back(m); q_out.push_back(rd[3:0]);
         q_req.push_back(1'b0); q_tag.push_back("R8 rdata lo");
         q_nib.push_back(4'hF); q_oe.push_back(m); q_out.push_back(rd[7:4]);
         q_req.push_back(1'b0); q_tag.push_back("R8 rdata hi");
      end
      q_nib.push_back(4'hF); q_oe.push_back(m); q_out.push_back(4'hF);
      q_req.push_back(1'b0); q_tag.push_back("R9 closing ones");
      q_nib.push_back(4'hF); q_oe.push_back(1'b0); q_out.push_back(4'hF);
      q_req.push_back(1'b0); q_tag.push_back("R9 float");
      for (int k = 0; k < q_nib.size() && k < stop; k++)
         cyc(k == 0, q_nib[k], q_oe[k], q_out[k], q_req[k], wr, a[19:0], d, q_tag[k]);
      if (wr && m && stop > 11)
         ref_mem[int'(a[19:0])] = d;
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      rst_n       = 1'b0;
      frame_start = 1'b0;
      bus_in      = 4'hF;
      id_strap    = 4'h0;
      repeat (3) @(negedge clk);
      chk("R1 reset oe", 32'(bus_oe), 32'd0);
      chk("R1 reset req", 32'(mem_req), 32'd0);
      rst_n = 1'b1;

      // basic write, read back
      xfer(1'b1, 4'hE, 4'h0, 28'h0000123, 8'hA5, 99, 1'b0, 4'hF);
      xfer(1'b0, 4'hD, 4'h0, 28'h0000123, 8'h00, 99, 1'b0, 4'hF);
      // R4: upper address bits ignored
      xfer(1'b1, 4'hE, 4'h0, 28'hFF12345, 8'h3C, 99, 1'b0, 4'hF);
      xfer(1'b0, 4'hD, 4'h0, 28'h0012345, 8'h00, 99, 1'b0, 4'hF);
      xfer(1'b0, 4'hD, 4'h0, 28'h0000777, 8'h00, 99, 1'b0, 4'hF);
      // R3: other device IDs stay silent; memory untouched
      xfer(1'b0, 4'hD, 4'h1, 28'h0000123, 8'h00, 99, 1'b0, 4'hF);
      xfer(1'b1, 4'hE, 4'h2, 28'h0000123, 8'h00, 99, 1'b0, 4'hF);
      xfer(1'b0, 4'hD, 4'h0, 28'h0000123, 8'h00, 99, 1'b0, 4'hF);
      // R3: non-zero strap
      id_strap = 4'h3;
      xfer(1'b0, 4'hD, 4'h3, 28'h0012345, 8'h00, 99, 1'b0, 4'hF);
      xfer(1'b0, 4'hD, 4'h0, 28'h0012345, 8'h00, 99, 1'b0, 4'hF);
      // R2: unknown start code ignored
      xfer(1'b1, 4'h7, 4'h3, 28'h0000123, 8'h11, 99, 1'b0, 4'hF);
      xfer(1'b0, 4'hD, 4'h3, 28'h0000123, 8'h00, 99, 1'b0, 4'hF);
      // R10: abort during address, then a full write and read
      xfer(1'b0, 4'hD, 4'h3, 28'h0000ABC, 8'h00, 5, 1'b0, 4'hF);
      xfer(1'b1, 4'hE, 4'h3, 28'h0000055, 8'h99, 99, 1'b0, 4'hF);
      xfer(1'b0, 4'hD, 4'h3, 28'h0000055, 8'h00, 99, 1'b0, 4'hF);
      // R10: abort in the sync field while driving; new write follows
      xfer(1'b0, 4'hD, 4'h3, 28'h0000055, 8'h00, 11, 1'b0, 4'hF);
      xfer(1'b1, 4'hE, 4'h3, 28'h0000066, 8'h5A, 99, 1'b1, 4'h0);
      xfer(1'b0, 4'hD, 4'h3, 28'h0000066, 8'h00, 99, 1'b0, 4'hF);
      // R1: reset while the target drives the bus
      xfer(1'b0, 4'hD, 4'h3, 28'h0000066, 8'h00, 12, 1'b0, 4'hF);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 mid reset oe", 32'(bus_oe), 32'd0);
      chk("R1 mid reset req", 32'(mem_req), 32'd0);
      rst_n = 1'b1;
      xfer(1'b0, 4'hD, 4'h3, 28'h0000066, 8'h00, 99, 1'b0, 4'hF);

      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule